// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the write-side controller of a small NOR-style parallel flash model. Host write cycles arrive on a plain bus with an address, up to four data bytes, a size code and a strobe. The block decodes them as a keyed command protocol. Two unlock cycles come first, then a command cycle, then any argument cycles. From these it carries out bit-clearing programs, sector erase and whole-array erase on an internal byte array. While an erase is in progress it counts down a busy window.

It also produces the signals that a separate read path needs. These are a read-mode code that selects array data, identification data, status or the query table, the status bit that flips when an operation ends, the bypass flag and a busy flag. A combinational four-byte port reads the array little-endian. A read-only input blocks every change to the array, while the command flow and the timing run exactly as usual.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: After reset, rd_mode is 0 (array), and busy, bypass and stat7 are all 0.
- R2: Commands are decoded from a word offset: the byte address within the sector (low SECTOR_W bits), shifted right by DEV_SHIFT. Unlocking takes 0xAA at offset UNLK0, then 0x55 at offset UNLK1, in any sector. Any other write during unlocking returns to read mode.
- R3: From read mode, or from identification mode, a write of 0x98 at offset 0x55 enters query mode (rd_mode 3). Any write made in query mode returns to read mode with bypass cleared.
- R4: The command cycle must be at offset UNLK0 unless bypass is set. In it, 0x90 selects identification (rd_mode 1), 0xA0 selects program (rd_mode 2) and 0x80 selects erase setup. Any other value, or a wrong offset, returns to read mode.
- R5: The write that follows 0xA0 ANDs its data into the array, least significant byte at the lowest address. wr_size 0 covers 1 byte, 1 covers 2 bytes, and 2 or 3 covers 4 bytes. stat7 becomes the inverse of data bit 7. The sequencer then returns to read mode, or to the command cycle if bypass is set.
- R6: Command 0x20 sets bypass, so that later commands need no unlock cycles. In identification mode with bypass set, a write of 0x00 clears bypass and returns to read mode.
- R7: A write of 0xF0 returns to read mode and clears bypass. This does not apply while a program is pending, where 0xF0 is programmed as data, or while busy.
- R8: After erase setup and a second unlock pair, 0x10 at offset UNLK0 sets every byte to 0xFF. stat7 is cleared and busy is high for exactly CHIP_CYC cycles.
- R9: After the same prefix, 0x30 at any address sets the whole addressed sector to 0xFF and leaves other sectors unchanged. busy is high for exactly SECT_CYC cycles.
- R10: While busy, writes are ignored and rd_mode is 2. When busy ends, stat7 inverts and the sequencer returns to read mode, or to the command cycle if bypass is set.
- R11: While ro is high, program and erase leave the array unchanged. stat7, busy and the mode sequence behave as without ro.
- R12: The rd_mode values are 0 for array, 1 for identification, 2 for status (program pending or erase busy) and 3 for query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data; bits 7:0 carry command codes |
| wr_size | input | 2 | Write size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| ro | input | 1 | Array write protect |
| rd_addr | input | ADDR_W | Byte address for the array read port |
| rd_data | output | 32 | Four bytes from rd_addr upward, little-endian |
| rd_mode | output | 2 | Read-path selector (see R12) |
| busy | output | 1 | Erase in progress |
| bypass | output | 1 | Unlock bypass active |
| stat7 | output | 1 | Completion status bit |

## Verification
The bench builds a 16-bit device (DEV_SHIFT = 1) with 256-byte sectors in a 1 KiB array. This puts the byte-to-word offset shift under test: an unlock written at the unshifted byte address must fail. Four sectors allow a sector erase to be checked against untouched neighbours. CHIP_CYC = 40 and SECT_CYC = 12 are short enough to measure both busy windows to the exact cycle. They also leave room to push an ignored write into a busy window and to run erases both with bypass set and with the array write-protected.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // read mode, waiting for first unlock cycle
    ST_UNLK1,  // first unlock seen
    ST_CMD,    // command cycle
    ST_ARG,    // argument cycle of the selected command
    ST_ARG2,   // second unlock of erase setup, second cycle
    ST_ERASE,  // erase selection cycle
    ST_BUSY,   // erase window running
    ST_QUERY   // query table mode
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ESETUP,
    OP_IDENT,
    OP_PROG,
    OP_CHIP,
    OP_SECT
  } seq_op_e;

  localparam logic [1:0] RM_ARRAY  = 2'd0;
  localparam logic [1:0] RM_IDENT  = 2'd1;
  localparam logic [1:0] RM_STATUS = 2'd2;
  localparam logic [1:0] RM_QUERY  = 2'd3;

  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_BYPASS  = 8'h20;
  localparam logic [7:0] CODE_ESETUP  = 8'h80;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECT    = 8'h30;
  localparam logic [7:0] CODE_QUERY   = 8'h98;
  localparam logic [7:0] CODE_ABORT   = 8'hF0;
  localparam logic [7:0] CODE_BYPEXIT = 8'h00;
  localparam int         QUERY_WOFF   = 'h55;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int WOFF_W = 7,
  parameter int UNLK0  = 'h55,
  parameter int UNLK1  = 'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WOFF_W-1:0] woff,
  input  logic [7:0]        wcode,
  input  logic              tmr_done,
  output seq_state_e        st_o,
  output seq_op_e           op_o,
  output logic              bypass_o,
  output logic              stat7_o,
  output logic              prog_go,
  output logic              chip_go,
  output logic              sect_go
);

  seq_state_e st_q, st_d;
  seq_op_e    op_q, op_d;
  logic       byp_q, byp_d;
  logic       stat_q, stat_d;
  logic       drop;
  logic       hit_u0, hit_u1, hit_q;
  logic       upd;

  assign hit_u0 = (woff == WOFF_W'(UNLK0));
  assign hit_u1 = (woff == WOFF_W'(UNLK1));
  assign hit_q  = (woff == WOFF_W'(QUERY_WOFF));
  assign upd    = wr_en | tmr_done;

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    byp_d   = byp_q;
    stat_d  = stat_q;
    drop    = 1'b0;
    prog_go = 1'b0;
    chip_go = 1'b0;
    sect_go = 1'b0;
    if (st_q == ST_BUSY) begin
      if (tmr_done) begin
        stat_d = ~stat_q;
        st_d   = byp_q ? ST_CMD : ST_IDLE;
        op_d   = OP_NONE;
      end
    end else if (wr_en) begin
      if (wcode == CODE_ABORT && op_q != OP_PROG) begin
        drop = 1'b1;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (hit_q && wcode == CODE_QUERY) begin
              st_d = ST_QUERY;
              op_d = OP_NONE;
            end else if (hit_u0 && wcode == CODE_KEY_A) st_d = ST_UNLK1;
            else drop = 1'b1;
          end
          ST_UNLK1: begin
            if (hit_u1 && wcode == CODE_KEY_B) st_d = ST_CMD;
            else drop = 1'b1;
          end
          ST_CMD: begin
            if (!byp_q && !hit_u0) drop = 1'b1;
            else begin
              unique case (wcode)
                CODE_BYPASS: byp_d = 1'b1;
                CODE_ESETUP: begin op_d = OP_ESETUP; st_d = ST_ARG; end
                CODE_IDENT:  begin op_d = OP_IDENT;  st_d = ST_ARG; end
                CODE_PROG:   begin op_d = OP_PROG;   st_d = ST_ARG; end
                default:     drop = 1'b1;
              endcase
            end
          end
          ST_ARG: begin
            unique case (op_q)
              OP_PROG: begin
                prog_go = 1'b1;
                stat_d  = ~wcode[7];
                st_d    = byp_q ? ST_CMD : ST_IDLE;
                op_d    = OP_NONE;
              end
              OP_ESETUP: begin
                if (hit_q && wcode == CODE_QUERY) begin
                  st_d = ST_QUERY;
                  op_d = OP_NONE;
                end else if (hit_u0 && wcode == CODE_KEY_A) st_d = ST_ARG2;
                else drop = 1'b1;
              end
              OP_IDENT: begin
                if (byp_q && wcode == CODE_BYPEXIT) drop = 1'b1;
                else if (hit_q && wcode == CODE_QUERY) begin
                  st_d = ST_QUERY;
                  op_d = OP_NONE;
                end else drop = 1'b1;
              end
              default: drop = 1'b1;
            endcase
          end
          ST_ARG2: begin
            if (hit_u1 && wcode == CODE_KEY_B) st_d = ST_ERASE;
            else drop = 1'b1;
          end
          ST_ERASE: begin
            if (wcode == CODE_CHIP && hit_u0) begin
              chip_go = 1'b1;
              stat_d  = 1'b0;
              st_d    = ST_BUSY;
              op_d    = OP_CHIP;
            end else if (wcode == CODE_SECT) begin
              sect_go = 1'b1;
              stat_d  = 1'b0;
              st_d    = ST_BUSY;
              op_d    = OP_SECT;
            end else drop = 1'b1;
          end
          default: drop = 1'b1;
        endcase
      end
      if (drop) begin
        st_d  = ST_IDLE;
        op_d  = OP_NONE;
        byp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_NONE;
      byp_q  <= 1'b0;
      stat_q <= 1'b0;
    end else if (upd) begin
      st_q   <= st_d;
      op_q   <= op_d;
      byp_q  <= byp_d;
      stat_q <= stat_d;
    end
  end

  assign st_o     = st_q;
  assign op_o     = op_q;
  assign bypass_o = byp_q;
  assign stat7_o  = stat_q;

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CHIP_CYC = 2000,
  parameter int SECT_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_go,
  input  logic sect_go,
  output logic busy,
  output logic done
);

  localparam int MAXC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          en;

  assign en   = chip_go | sect_go | busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (chip_go) begin
      cnt_d  = CW'(CHIP_CYC - 1);
      busy_d = 1'b1;
    end else if (sect_go) begin
      cnt_d  = CW'(SECT_CYC - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int ADDR_W   = 9,
  parameter int SECTOR_W = 7
) (
  input  logic              clk,
  input  logic              prog_en,
  input  logic              chip_en,
  input  logic              sect_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = 4;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] pidx  [LANES];
  logic              plane [LANES];
  logic [ADDR_W-1:0] sect_base;

  assign sect_base = addr >> SECTOR_W;

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      pidx[b]  = addr + ADDR_W'(b);
      plane[b] = (b == 0) || (b == 1 && size != 2'd0) || (b >= 2 && size[1]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (chip_en || (sect_en && ((ADDR_W'(i) >> SECTOR_W) == sect_base)))
        mem[i] <= 8'hFF;
    end
    for (int b = 0; b < LANES; b++) begin
      if (prog_en && plane[b])
        mem[pidx[b]] <= mem[pidx[b]] & wdata[8*b +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    logic [ADDR_W-1:0] ridx;
    assign ridx = rd_addr + ADDR_W'(g);
    assign rd_data[8*g +: 8] = mem[ridx];
  end

endmodule

// File: rtl/flash_cmd_sequencer.sv
module flash_cmd_sequencer
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int SECTOR_W  = 7,
  parameter int DEV_SHIFT = 0,
  parameter int UNLK0     = 'h55,
  parameter int UNLK1     = 'h2A,
  parameter int CHIP_CYC  = 2000,
  parameter int SECT_CYC  = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        wr_size,
  input  logic              ro,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [1:0]        rd_mode,
  output logic              busy,
  output logic              bypass,
  output logic              stat7
);

  localparam int WOFF_W = SECTOR_W - DEV_SHIFT;

  seq_state_e        st;
  seq_op_e           op;
  logic [WOFF_W-1:0] woff;
  logic              prog_go, chip_go, sect_go, tmr_done;

  assign woff = wr_addr[SECTOR_W-1:DEV_SHIFT];

  flash_cmd_fsm #(.WOFF_W(WOFF_W), .UNLK0(UNLK0), .UNLK1(UNLK1)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .woff(woff), .wcode(wr_data[7:0]),
    .tmr_done(tmr_done), .st_o(st), .op_o(op), .bypass_o(bypass), .stat7_o(stat7),
    .prog_go(prog_go), .chip_go(chip_go), .sect_go(sect_go)
  );

  flash_busy_timer #(.CHIP_CYC(CHIP_CYC), .SECT_CYC(SECT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .chip_go(chip_go), .sect_go(sect_go),
    .busy(busy), .done(tmr_done)
  );

  flash_byte_array #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_arr (
    .clk(clk), .prog_en(prog_go & ~ro), .chip_en(chip_go & ~ro),
    .sect_en(sect_go & ~ro), .addr(wr_addr), .wdata(wr_data), .size(wr_size),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_comb begin
    if (st == ST_QUERY) rd_mode = RM_QUERY;
    else if (op == OP_IDENT) rd_mode = RM_IDENT;
    else if (op == OP_PROG || op == OP_CHIP || op == OP_SECT) rd_mode = RM_STATUS;
    else rd_mode = RM_ARRAY;
  end

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [1:0]  rd_mode,
  input logic        busy,
  input logic        bypass,
  input logic        stat7
);

  p_busy_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_mode == 2'd2);

  p_busy_bypass_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bypass == $past(bypass));

  p_done_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> stat7 != $past(stat7));

  p_query_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd3 && wr_en) |=> (rd_mode == 2'd0 && !bypass));

  p_prog_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2 && !busy && wr_en) |=> stat7 == !$past(wr_data[7]));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:0] == 8'hF0 && rd_mode != 2'd2) |=> (rd_mode == 2'd0 && !bypass));

  p_bypass_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'h20));

endmodule

bind flash_cmd_sequencer flash_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_mode(rd_mode),
  .busy(busy), .bypass(bypass), .stat7(stat7)
);

// File: tb/tb_flash_cmd_sequencer.sv
module tb_flash_cmd_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 10;
  localparam int SW   = 8;
  localparam int DS   = 1;
  localparam int U0   = 'h55;
  localparam int U1   = 'h2A;
  localparam int CHIP = 40;
  localparam int SECT = 12;

  localparam int K_MODE = 0, K_BYP = 1, K_STAT = 2, K_BUSY = 3, K_MEM = 4, K_NUM = 5;

  typedef struct {
    string       req;
    int          kind;
    logic [AW-1:0] addr;
    logic [31:0] exp;
    logic [31:0] act;
  } item_t;

  logic          clk, rst_n, wr_en, ro;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic [1:0]    wr_size, rd_mode;
  logic          busy, bypass, stat7;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  flash_cmd_sequencer #(
    .ADDR_W(AW), .SECTOR_W(SW), .DEV_SHIFT(DS), .UNLK0(U0), .UNLK1(U1),
    .CHIP_CYC(CHIP), .SECT_CYC(SECT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_size(wr_size), .ro(ro), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_mode(rd_mode), .busy(busy), .bypass(bypass), .stat7(stat7)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [AW-1:0] wa(int sec, int woff);
    return AW'((sec << SW) | (woff << DS));
  endfunction

  task automatic push(string req, int kind, logic [AW-1:0] a, logic [31:0] e, logic [31:0] act);
    item_t it;
    it.req = req; it.kind = kind; it.addr = a; it.exp = e; it.act = act;
    sbq.push_back(it);
  endtask

  task automatic exp_sig(string req, int kind, logic [31:0] e);
    push(req, kind, '0, e, '0);
  endtask

  task automatic exp_mem(string req, logic [AW-1:0] a, logic [31:0] e);
    push(req, K_MEM, a, e, '0);
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [1:0] s = 2'd0);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_size = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock(int sec);
    wr(wa(sec, U0), 32'hAA);
    wr(wa(sec, U1), 32'h55);
  endtask

  task automatic erase_prefix();
    unlock(0);
    wr(wa(0, U0), 32'h80);
    unlock(0);
  endtask

  task automatic wait_idle(input int start, output int n);
    n = start;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Monitor: pops expectations and compares them with the outputs
  initial begin
    rd_addr = '0;
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        case (it.kind)
          K_MODE: act = {30'd0, rd_mode};
          K_BYP:  act = {31'd0, bypass};
          K_STAT: act = {31'd0, stat7};
          K_BUSY: act = {31'd0, busy};
          K_MEM: begin
            rd_addr = it.addr;
            #1;
            act = rd_data;
          end
          default: act = it.act;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind %0d addr %h actual %h expected %h",
                   it.req, it.kind, it.addr, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_size = '0; ro = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    exp_sig("R1", K_MODE, 0); exp_sig("R1", K_BUSY, 0);
    exp_sig("R1", K_BYP, 0);  exp_sig("R1", K_STAT, 0);

    // R8 chip erase with exact busy window
    erase_prefix();
    wr(wa(0, U0), 32'h10);
    exp_sig("R8", K_BUSY, 1); exp_sig("R12", K_MODE, 2); exp_sig("R8", K_STAT, 0);
    wait_idle(0, n);
    push("R8", K_NUM, '0, CHIP, n);
    exp_sig("R10", K_STAT, 1); exp_sig("R10", K_MODE, 0);
    exp_mem("R8", 10'h000, 32'hFFFF_FFFF);
    exp_mem("R8", 10'h1F0, 32'hFFFF_FFFF);
    exp_mem("R8", 10'h3FC, 32'hFFFF_FFFF);

    // R5 program, AND semantics and sizes
    unlock(0); wr(wa(0, U0), 32'hA0);
    exp_sig("R12", K_MODE, 2);
    wr(10'h104, 32'h1234_5678, 2'd2);
    exp_sig("R5", K_MODE, 0); exp_sig("R5", K_STAT, 1);
    exp_mem("R5", 10'h104, 32'h1234_5678);
    unlock(0); wr(wa(0, U0), 32'hA0);
    wr(10'h104, 32'h0000_000F, 2'd0);
    exp_mem("R5", 10'h104, 32'h1234_5608);
    unlock(0); wr(wa(0, U0), 32'hA0);
    wr(10'h106, 32'h0000_0080, 2'd1);
    exp_sig("R5", K_STAT, 0);
    exp_mem("R5", 10'h104, 32'h0000_5608);
    unlock(0); wr(wa(0, U0), 32'hA0);
    wr(10'h104, 32'hFFFF_FFFF, 2'd2);
    exp_mem("R5", 10'h104, 32'h0000_5608);

    // R2 unlock at the unshifted byte address must fail
    wr(10'h055, 32'hAA); wr(wa(0, U1), 32'h55); wr(wa(0, U0), 32'hA0);
    wr(10'h200, 32'h0, 2'd2);
    exp_sig("R2", K_MODE, 0);
    exp_mem("R2", 10'h200, 32'hFFFF_FFFF);

    // R2 unlock in another sector, R4 identification, R3 query entry and exit
    unlock(2); wr(wa(2, U0), 32'h90);
    exp_sig("R4", K_MODE, 1);
    wr(wa(2, 'h55), 32'h98);
    exp_sig("R3", K_MODE, 3);
    wr(10'h000, 32'h12);
    exp_sig("R3", K_MODE, 0);
    wr(wa(1, 'h55), 32'h98);
    exp_sig("R3", K_MODE, 3);
    wr(10'h000, 32'h00);
    exp_sig("R3", K_MODE, 0);

    // R4 unknown command and wrong command offset
    unlock(0); wr(wa(0, U0), 32'h77);
    exp_sig("R4", K_MODE, 0);
    wr(10'h200, 32'h0, 2'd2);
    exp_mem("R4", 10'h200, 32'hFFFF_FFFF);
    unlock(0); wr(wa(0, U1), 32'hA0);
    exp_sig("R4", K_MODE, 0);
    wr(10'h200, 32'h0, 2'd2);
    exp_mem("R4", 10'h200, 32'hFFFF_FFFF);

    // R7 abort from identification and query
    unlock(0); wr(wa(0, U0), 32'h90); wr(10'h010, 32'hF0);
    exp_sig("R7", K_MODE, 0);
    wr(wa(0, 'h55), 32'h98); wr(10'h010, 32'hF0);
    exp_sig("R7", K_MODE, 0);

    // R6 bypass, program without unlock, R7 0xF0 as program data
    unlock(0); wr(wa(0, U0), 32'h20);
    exp_sig("R6", K_BYP, 1); exp_sig("R6", K_MODE, 0);
    wr(10'h3F0, 32'hA0);
    exp_sig("R6", K_MODE, 2);
    wr(10'h300, 32'h0000_FFFF, 2'd2);
    exp_sig("R6", K_BYP, 1);
    exp_mem("R6", 10'h300, 32'h0000_FFFF);
    wr(10'h3F0, 32'hA0);
    wr(10'h300, 32'h0000_00F0, 2'd0);
    exp_sig("R7", K_BYP, 1); exp_sig("R5", K_STAT, 0);
    exp_mem("R7", 10'h300, 32'h0000_FFF0);
    wr(10'h000, 32'hF0);
    exp_sig("R7", K_BYP, 0);
    unlock(0); wr(wa(0, U0), 32'h20);
    wr(10'h088, 32'h90);
    exp_sig("R6", K_MODE, 1);
    wr(10'h088, 32'h00);
    exp_sig("R6", K_BYP, 0); exp_sig("R6", K_MODE, 0);

    // R11 read-only sector erase, R10 ignored write while busy
    ro = 1'b1;
    erase_prefix();
    wr(10'h310, 32'h30);
    exp_sig("R9", K_BUSY, 1); exp_sig("R11", K_STAT, 0);
    wr(10'h000, 32'hF0);
    exp_sig("R10", K_BUSY, 1); exp_sig("R10", K_MODE, 2);
    wait_idle(1, n);
    push("R11", K_NUM, '0, SECT, n);
    exp_sig("R11", K_STAT, 1);
    exp_mem("R11", 10'h300, 32'h0000_FFF0);
    ro = 1'b0;

    // R9 sector erase only touches its own sector
    erase_prefix();
    wr(10'h3FC, 32'h30);
    wait_idle(0, n);
    push("R9", K_NUM, '0, SECT, n);
    exp_mem("R9", 10'h300, 32'hFFFF_FFFF);
    exp_mem("R9", 10'h104, 32'h0000_5608);

    // R10 erase completion with bypass returns to command cycle
    unlock(0); wr(wa(0, U0), 32'h20);
    wr(10'h000, 32'h80);
    unlock(0);
    wr(10'h104, 32'h30);
    exp_sig("R10", K_BUSY, 1);
    wait_idle(0, n);
    exp_sig("R10", K_BYP, 1); exp_sig("R10", K_MODE, 0);
    exp_mem("R10", 10'h104, 32'hFFFF_FFFF);
    wr(10'h2E0, 32'hA0);
    wr(10'h104, 32'h0, 2'd0);
    exp_mem("R10", 10'h104, 32'hFFFF_FF00);
    wr(10'h000, 32'hF0);
    exp_sig("R7", K_BYP, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule